// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block sits between the peripheral interrupt lines of a small multiprocessor system and the interrupt inputs of each processor. Each source has a pending bit, an enable bit, a trigger mode, an 8-bit priority byte and a processor-target mask. A source is forwarded to a processor when the block is globally enabled and the source is enabled, pending and aimed at that processor. Software programs the block through a simple 32-bit register bus. The bus carries the number of the processor making each access.

Sources 0 to 31 are private to each processor. Their enable and pending state exists once per processor behind the same addresses. Sources 0 to 15 are raised only by software, through a dedicated software-interrupt register. Sources 16 to 31 come from per-processor peripheral lines, and sources 32 and up come from shared peripheral lines. Each processor acknowledges a source by presenting its ID on its acknowledge port. The forwarded state comes out as one flat vector per processor, and the priority fields are stored for the processor side to use.

Top module: `idist_top`

## Requirements
- R1: After reset every forwarded bit is 0, bus_rdata is 0, global forwarding is off, every enable bit is 0 and every programmable source is level-triggered.
- R2: Writing 1s to the enable-set word at 0x100+4w enables those sources, and writing 1s to the enable-clear word at 0x180+4w disables them. Zero bits leave enables unchanged, and both addresses read back the current enables. Source n sits at bit n mod 32 of word n/32, and word 0 is the private bank of the accessing processor.
- R3: Bit 0 of the control register at 0x000 is read/write. While it is 0, no source is forwarded to any processor.
- R4: The read-only register at 0x004 returns NSRC/32-1 in bits 4:0, and writes to it are ignored.
- R5: The trigger fields live at 0xC00+4*(n/16), two bits per source at bits 2*(n mod 16)+1 to 2*(n mod 16). The upper bit selects edge (1) or level (0), and the lower bit reads 0. Fields for sources 0 to 15 always read 2'b10, and writes to them are ignored.
- R6: Source n owns a read/write 8-bit priority byte at address 0x400+n, which is byte lane n mod 4 of its word.
- R7: Source n owns a target byte at address 0x800+n, in byte lane n mod 4. Bit c selects processor c, only the low NCPU bits are stored and the rest read 0. Bytes for sources 0 to 31 read back as 1 shifted left by the reader's number, and writes to them are ignored. A shared source is forwarded to processor c only if bit c of its target byte is set.
- R8: Enables and pending bits of sources 0 to 31 are held separately per processor, so a change made by one processor does not affect another processor's copy.
- R9: A write to 0xF00 carries a processor list in bits 23:16 and an ID in bits 3:0, with bits 9:4 zero. It makes that ID pending on each listed processor, and the ID stays pending until that processor acknowledges it. A write with bits 9:4 nonzero is ignored.
- R10: An edge-triggered source becomes pending the cycle after a rising input edge and stays pending until any processor acknowledges its ID. A new edge in the same cycle as an acknowledge wins.
- R11: A level-triggered source is pending exactly when its input was high on the previous clock, and an acknowledge has no effect on it.
- R12: Reads of unimplemented addresses return 0, and writes to them change nothing.
- R13: Read data appears on bus_rdata in the cycle after the read request and is 0 otherwise. irq_fwd bit c*NSRC+s reflects the registered state without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CW | Number of the processor making the access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| ppi_in | input | NCPU*16 | Private peripheral lines, 16 per processor (sources 16..31) |
| spi_in | input | NSRC-32 | Shared peripheral lines (sources 32..NSRC-1) |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_id | input | NCPU*IDW | Per-processor acknowledged source ID |
| irq_fwd | output | NCPU*NSRC | Forwarded sources, bit c*NSRC+s |

## Verification
The bench sweeps every priority, target and trigger word, and it checks the enable words from both processors. A design that failed to bank enables would show one processor's writes in the other's word 0. A design that failed to mask the fixed fields would read back 1s in the low bits of the trigger fields or in the software-interrupt fields. It also checks a rising edge that arrives together with an acknowledge, which a design that let the acknowledge win would drop. It checks an acknowledge of a level source, which must not clear the source while the line is high. It checks a software interrupt with a malformed ID and a shared source aimed at one processor only. Each of these would show up as a stray or missing bit in irq_fwd.

// File: rtl/idist_pkg.sv
package idist_pkg;
    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_TYPE  = 12'h004;
    localparam logic [11:0] OFS_ENSET = 12'h100;
    localparam logic [11:0] OFS_ENCLR = 12'h180;
    localparam logic [11:0] OFS_PRIO  = 12'h400;
    localparam logic [11:0] OFS_TGT   = 12'h800;
    localparam logic [11:0] OFS_CFG   = 12'hC00;
    localparam logic [11:0] OFS_SGI   = 12'hF00;
    localparam int          NPRIV     = 32;
    localparam int          NSOFT     = 16;
endpackage

// File: rtl/idist_srcbank.sv
module idist_srcbank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sig_in,
    input  logic [N-1:0] is_edge,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] en_q,
    output logic [N-1:0] pend_q
);
    typedef struct packed {
        logic         armed;
        logic [N-1:0] en;
        logic [N-1:0] pend;
        logic [N-1:0] prev;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.en    = (st_q.en | en_set) & ~en_clr;
        st_d.prev  = sig_in;
        for (int i = 0; i < N; i++) begin
            if (is_edge[i])
                st_d.pend[i] = (st_q.pend[i] & ~ack_clr[i]) | sw_set[i]
                             | (sig_in[i] & ~st_q.prev[i]);
            else
                st_d.pend[i] = sig_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;

    // R2
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));
    // R9
    sw_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && sw_set != '0) |=> ((pend_q & $past(sw_set)) == $past(sw_set)));
    // R11
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> ((pend_q & ~$past(is_edge)) == ($past(sig_in) & ~$past(is_edge))));
endmodule

// File: rtl/idist_top.sv
module idist_top
    import idist_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int NCPU = 2,
    localparam int NSH   = NSRC - NPRIV,
    localparam int NWORD = NSRC / 32,
    localparam int IDW   = $clog2(NSRC),
    localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int NCFG  = NSRC - NSOFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_vld,
    input  logic                 bus_wr,
    input  logic [CW-1:0]        bus_cpu,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NCPU*16-1:0]   ppi_in,
    input  logic [NSH-1:0]       spi_in,
    input  logic [NCPU-1:0]      ack_vld,
    input  logic [NCPU*IDW-1:0]  ack_id,
    output logic [NCPU*NSRC-1:0] irq_fwd
);
    typedef struct packed {
        logic                      ctrl_en;
        logic [NSRC-1:0][7:0]      prio;
        logic [NSH-1:0][NCPU-1:0]  tgt;
        logic [NCFG-1:0]           trig_edge;
        logic [31:0]               rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr, rd;
    logic [NCPU-1:0][31:0] bk_set, bk_clr, bk_sw, bk_ack, bk_in, bk_edge, bk_en, bk_pend;
    logic [NSH-1:0]        sh_set, sh_clr, sh_ack, sh_en, sh_pend;
    logic [IDW-1:0]        cur_id;

    always_comb begin
        wr   = bus_vld & bus_wr;
        rd   = bus_vld & ~bus_wr;
        r_d  = r_q;
        r_d.rdata = '0;
        cur_id = '0;

        // private banks: enables, software interrupts, acknowledges
        for (int c = 0; c < NCPU; c++) begin
            bk_set[c]  = (wr && 32'(bus_cpu) == c && bus_addr == OFS_ENSET) ? bus_wdata : '0;
            bk_clr[c]  = (wr && 32'(bus_cpu) == c && bus_addr == OFS_ENCLR) ? bus_wdata : '0;
            bk_sw[c]   = '0;
            if (wr && bus_addr == OFS_SGI && bus_wdata[9:4] == '0 && bus_wdata[16+c])
                bk_sw[c][bus_wdata[3:0]] = 1'b1;
            bk_ack[c]  = '0;
            if (ack_vld[c] && ack_id[c*IDW +: IDW] < IDW'(NPRIV))
                bk_ack[c][ack_id[c*IDW +: 5]] = 1'b1;
            bk_in[c]   = {ppi_in[c*16 +: 16], 16'h0000};
            bk_edge[c] = {r_q.trig_edge[15:0], 16'hFFFF};
        end

        // shared sources
        sh_set = '0;
        sh_clr = '0;
        for (int w = 1; w < NWORD; w++) begin
            if (wr && bus_addr == OFS_ENSET + 12'(4*w)) sh_set[(w-1)*32 +: 32] = bus_wdata;
            if (wr && bus_addr == OFS_ENCLR + 12'(4*w)) sh_clr[(w-1)*32 +: 32] = bus_wdata;
        end
        sh_ack = '0;
        for (int c = 0; c < NCPU; c++) begin
            cur_id = ack_id[c*IDW +: IDW];
            if (ack_vld[c] && cur_id >= IDW'(NPRIV))
                sh_ack[cur_id - IDW'(NPRIV)] = 1'b1;
        end

        // register writes
        if (wr && bus_addr == OFS_CTRL) r_d.ctrl_en = bus_wdata[0];
        for (int s = 0; s < NSRC; s++)
            if (wr && bus_addr == OFS_PRIO + 12'((s/4)*4))
                r_d.prio[s] = bus_wdata[8*(s%4) +: 8];
        for (int s = NPRIV; s < NSRC; s++)
            if (wr && bus_addr == OFS_TGT + 12'((s/4)*4))
                r_d.tgt[s-NPRIV] = bus_wdata[8*(s%4) +: NCPU];
        for (int s = NSOFT; s < NSRC; s++)
            if (wr && bus_addr == OFS_CFG + 12'((s/16)*4))
                r_d.trig_edge[s-NSOFT] = bus_wdata[2*(s%16)+1];

        // register reads
        if (rd) begin
            if (bus_addr == OFS_CTRL) r_d.rdata = {31'b0, r_q.ctrl_en};
            if (bus_addr == OFS_TYPE) r_d.rdata = {27'b0, 5'(NWORD-1)};
            for (int w = 0; w < NWORD; w++)
                if (bus_addr == OFS_ENSET + 12'(4*w) || bus_addr == OFS_ENCLR + 12'(4*w))
                    r_d.rdata = (w == 0) ? bk_en[bus_cpu] : sh_en[(w-1)*32 +: 32];
            for (int s = 0; s < NSRC; s++)
                if (bus_addr == OFS_PRIO + 12'((s/4)*4))
                    r_d.rdata[8*(s%4) +: 8] = r_q.prio[s];
            for (int s = 0; s < NPRIV; s++)
                if (bus_addr == OFS_TGT + 12'((s/4)*4))
                    r_d.rdata[8*(s%4) +: 8] = 8'(1) << bus_cpu;
            for (int s = NPRIV; s < NSRC; s++)
                if (bus_addr == OFS_TGT + 12'((s/4)*4))
                    r_d.rdata[8*(s%4) +: 8] = 8'(r_q.tgt[s-NPRIV]);
            for (int s = 0; s < NSOFT; s++)
                if (bus_addr == OFS_CFG)
                    r_d.rdata[2*s +: 2] = 2'b10;
            for (int s = NSOFT; s < NSRC; s++)
                if (bus_addr == OFS_CFG + 12'((s/16)*4))
                    r_d.rdata[2*(s%16) +: 2] = {r_q.trig_edge[s-NSOFT], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        idist_srcbank #(.N(NPRIV)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_set  (bk_set[c]),
            .en_clr  (bk_clr[c]),
            .sw_set  (bk_sw[c]),
            .sig_in  (bk_in[c]),
            .is_edge (bk_edge[c]),
            .ack_clr (bk_ack[c]),
            .en_q    (bk_en[c]),
            .pend_q  (bk_pend[c])
        );
    end

    idist_srcbank #(.N(NSH)) u_shared (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (sh_set),
        .en_clr  (sh_clr),
        .sw_set  ('0),
        .sig_in  (spi_in),
        .is_edge (r_q.trig_edge[NCFG-1:NPRIV-NSOFT]),
        .ack_clr (sh_ack),
        .en_q    (sh_en),
        .pend_q  (sh_pend)
    );

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int s = 0; s < NPRIV; s++)
                irq_fwd[c*NSRC+s] = r_q.ctrl_en & bk_en[c][s] & bk_pend[c][s];
            for (int s = NPRIV; s < NSRC; s++)
                irq_fwd[c*NSRC+s] = r_q.ctrl_en & sh_en[s-NPRIV] & sh_pend[s-NPRIV]
                                  & r_q.tgt[s-NPRIV][c];
        end
    end

    assign bus_rdata = r_q.rdata;

    // R3
    fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_CTRL && !bus_wdata[0]) |=> (irq_fwd == '0));
    // R4
    type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_TYPE) |=> (bus_rdata == 32'(NWORD-1)));
    // R5
    soft_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == OFS_CFG) |=> (bus_rdata == {16{2'b10}}));
    // R13
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (bus_rdata == '0));
endmodule

// File: tb/test_idist_top.sv
`timescale 1ns/1ps
module test_idist_top;
    localparam int NSRC = 64;
    localparam int NCPU = 2;
    localparam int IDW  = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_vld = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [0:0]           bus_cpu = '0;
    logic [11:0]          bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NCPU*16-1:0]   ppi_in = '0;
    logic [NSRC-33:0]     spi_in = '0;
    logic [NCPU-1:0]      ack_vld = '0;
    logic [NCPU*IDW-1:0]  ack_id = '0;
    logic [NCPU*NSRC-1:0] irq_fwd;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;
    logic [31:0] exp_bank [NCPU];
    logic [31:0] exp_sh;
    logic [31:0] ew;

    always #2.5 clk = ~clk;

    idist_top #(.NSRC(NSRC), .NCPU(NCPU)) i_idist_top (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ppi_in(ppi_in), .spi_in(spi_in),
        .ack_vld(ack_vld), .ack_id(ack_id), .irq_fwd(irq_fwd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_cpu = 1'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_cpu = 1'(cpu); bus_addr = a;
        @(negedge clk);
        bus_vld = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input int cpu, input int id);
        @(negedge clk);
        ack_vld[cpu] = 1'b1; ack_id[cpu*IDW +: IDW] = IDW'(id);
        @(negedge clk);
        ack_vld[cpu] = 1'b0;
    endtask

    function automatic logic fwd(input int cpu, input int s);
        return irq_fwd[cpu*NSRC+s];
    endfunction

    function automatic logic [7:0] prio_pat(input int s);
        return 8'((s*37 + 11) & 255);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fwd", 32'(irq_fwd != '0), 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rd_reg(0, 12'h000, rv); check("R1 ctrl", rv, 32'd0);
        rd_reg(1, 12'h100, rv); check("R1 enable", rv, 32'd0);
        rd_reg(0, 12'hC08, rv); check("R1 trigger", rv, 32'd0);

        // R4 type register, read-only
        rd_reg(0, 12'h004, rv); check("R4 type", rv, 32'd1);
        wr_reg(0, 12'h004, 32'hFFFF_FFFF);
        rd_reg(1, 12'h004, rv); check("R4 type after write", rv, 32'd1);

        // R2 / R8 enable words, banked word 0
        exp_bank[0] = '0; exp_bank[1] = '0; exp_sh = '0;
        for (int c = 0; c < NCPU; c++) begin
            wr_reg(c, 12'h100, 32'hA5A5_0F0F ^ (32'h1111_1111 * (c+1)));
            exp_bank[c] |= 32'hA5A5_0F0F ^ (32'h1111_1111 * (c+1));
        end
        wr_reg(0, 12'h180, 32'h0000_FFFF); exp_bank[0] &= ~32'h0000_FFFF;
        wr_reg(1, 12'h100, 32'h0000_0000);
        for (int c = 0; c < NCPU; c++) begin
            rd_reg(c, 12'h100, rv); check("R2 R8 set-word read", rv, exp_bank[c]);
            rd_reg(c, 12'h180, rv); check("R2 R8 clear-word read", rv, exp_bank[c]);
        end
        wr_reg(0, 12'h104, 32'h8000_0101); exp_sh |= 32'h8000_0101;
        wr_reg(1, 12'h104, 32'h0F00_0000); exp_sh |= 32'h0F00_0000;
        wr_reg(1, 12'h184, 32'h8000_0001); exp_sh &= ~32'h8000_0001;
        rd_reg(0, 12'h104, rv); check("R2 shared word", rv, exp_sh);
        rd_reg(1, 12'h184, rv); check("R2 shared word clr", rv, exp_sh);
        for (int c = 0; c < NCPU; c++) wr_reg(c, 12'h180, 32'hFFFF_FFFF);
        wr_reg(0, 12'h184, 32'hFFFF_FFFF);
        rd_reg(1, 12'h100, rv); check("R2 cleared", rv, 32'd0);

        // R6 priority sweep
        for (int w = 0; w < NSRC/4; w++)
            wr_reg(w % 2, 12'(12'h400 + 4*w),
                   {prio_pat(4*w+3), prio_pat(4*w+2), prio_pat(4*w+1), prio_pat(4*w)});
        for (int w = 0; w < NSRC/4; w++) begin
            rd_reg(0, 12'(12'h400 + 4*w), rv);
            check("R6 priority", rv, {prio_pat(4*w+3), prio_pat(4*w+2), prio_pat(4*w+1), prio_pat(4*w)});
        end

        // R7 target sweep
        for (int w = 0; w < NSRC/4; w++)
            wr_reg(0, 12'(12'h800 + 4*w), 32'(w) * 32'h0D1F_2B37);
        for (int w = 0; w < NSRC/4; w++) begin
            for (int c = 0; c < NCPU; c++) begin
                rd_reg(c, 12'(12'h800 + 4*w), rv);
                if (w < 8) ew = {4{8'(1 << c)}};
                else       ew = (32'(w) * 32'h0D1F_2B37) & 32'h0303_0303;
                check("R7 target", rv, ew);
            end
        end

        // R5 trigger fields
        for (int w = 0; w < NSRC/16; w++) wr_reg(0, 12'(12'hC00 + 4*w), 32'hFFFF_FFFF);
        for (int w = 0; w < NSRC/16; w++) begin
            rd_reg(1, 12'(12'hC00 + 4*w), rv); check("R5 trigger all-ones", rv, 32'hAAAA_AAAA);
        end
        for (int w = 0; w < NSRC/16; w++) wr_reg(0, 12'(12'hC00 + 4*w), 32'h0);
        rd_reg(0, 12'hC00, rv); check("R5 soft fields fixed", rv, 32'hAAAA_AAAA);
        for (int w = 1; w < NSRC/16; w++) begin
            rd_reg(0, 12'(12'hC00 + 4*w), rv); check("R5 trigger zero", rv, 32'h0);
        end

        // R12 unimplemented addresses
        wr_reg(0, 12'h040, 32'hFFFF_FFFF);
        rd_reg(0, 12'h040, rv); check("R12 unimplemented", rv, 32'h0);
        wr_reg(0, 12'h108, 32'hFFFF_FFFF);
        rd_reg(0, 12'h108, rv); check("R12 beyond enables", rv, 32'h0);
        rd_reg(0, 12'h000, rv); check("R12 ctrl untouched", rv, 32'h0);

        // forwarding setup
        wr_reg(0, 12'h000, 32'h1);
        rd_reg(1, 12'h000, rv); check("R3 ctrl read", rv, 32'h1);
        wr_reg(0, 12'h828, 32'h0000_0001);   // source 40 -> cpu0
        wr_reg(0, 12'h830, 32'h0003_0000);   // source 50 -> both
        wr_reg(0, 12'hC08, 32'h0002_0000);   // source 40 edge
        wr_reg(0, 12'h104, 32'h0004_0100);   // enable 40, 50

        // R11 level source 50
        @(negedge clk); spi_in[18] = 1'b1;
        @(negedge clk);
        check("R11 level cpu0", 32'(fwd(0, 50)), 32'd1);
        check("R11 level cpu1", 32'(fwd(1, 50)), 32'd1);
        ack(0, 50);
        check("R11 ack ignored", 32'(fwd(0, 50)), 32'd1);
        @(negedge clk); spi_in[18] = 1'b0;
        @(negedge clk);
        check("R11 level drop", 32'(fwd(1, 50)), 32'd0);

        // R10 edge source 40, R7 targeting
        @(negedge clk); spi_in[8] = 1'b1;
        @(negedge clk); spi_in[8] = 1'b0;
        check("R10 edge latched", 32'(fwd(0, 40)), 32'd1);
        check("R7 not targeted", 32'(fwd(1, 40)), 32'd0);
        repeat (3) @(negedge clk);
        check("R10 edge held", 32'(fwd(0, 40)), 32'd1);
        ack(1, 40);
        check("R10 ack clears", 32'(fwd(0, 40)), 32'd0);
        @(negedge clk);
        spi_in[8] = 1'b1; ack_vld[0] = 1'b1; ack_id[0 +: IDW] = IDW'(40);
        @(negedge clk);
        ack_vld[0] = 1'b0;
        check("R10 edge beats ack", 32'(fwd(0, 40)), 32'd1);
        spi_in[8] = 1'b0;
        ack(0, 40);
        check("R10 cleared again", 32'(fwd(0, 40)), 32'd0);

        // R9 software interrupts
        wr_reg(0, 12'h100, 32'h20);
        wr_reg(1, 12'h100, 32'h20);
        wr_reg(0, 12'hF00, 32'h0002_0005);
        check("R9 listed cpu", 32'(fwd(1, 5)), 32'd1);
        check("R9 unlisted cpu", 32'(fwd(0, 5)), 32'd0);
        wr_reg(1, 12'hF00, 32'h0001_0025);
        check("R9 malformed ignored", 32'(fwd(0, 5)), 32'd0);
        ack(1, 5);
        check("R9 ack", 32'(fwd(1, 5)), 32'd0);

        // R8 private peripheral banking
        wr_reg(0, 12'h100, 32'h0008_0000);
        @(negedge clk); ppi_in[3] = 1'b1; ppi_in[19] = 1'b1;
        @(negedge clk);
        check("R8 cpu0 enabled", 32'(fwd(0, 19)), 32'd1);
        check("R8 cpu1 own enable", 32'(fwd(1, 19)), 32'd0);
        wr_reg(1, 12'h100, 32'h0008_0000);
        check("R8 cpu1 enabled", 32'(fwd(1, 19)), 32'd1);

        // R3 global enable
        wr_reg(1, 12'h000, 32'h0);
        check("R3 gated", 32'(irq_fwd != '0), 32'd0);
        wr_reg(1, 12'h000, 32'h1);
        check("R3 restored", 32'(fwd(0, 19)), 32'd1);

        // R13 read latency
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = 12'h004;
        check("R13 no early data", bus_rdata, 32'h0);
        @(negedge clk);
        bus_vld = 1'b0;
        check("R13 data next cycle", bus_rdata, 32'h1);
        @(negedge clk);
        check("R13 idle zero", bus_rdata, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule